// File: doc/BRIEF.md
# Reconfigurable Lookup Memory Cell

This block is one logic cell built around a 64-bit store. A static mode select decides how that store is used. It can serve as one 6-input function, as two 5-input functions that share their address, as a 64x1 or dual 32x1 RAM with synchronous write, as one 32-stage shift register with an addressable tap, or as two 16-stage shift registers with their own taps. Function contents are loaded through the same write port that RAM mode uses, so one write sequence at start-up configures the cell.

Two outputs leave the cell: a main output and an auxiliary output. Each one can pass straight from the read multiplexer or go through its own flip-flop, chosen per output by a static select. The cell has no streaming data, so every pin is a plain control or data pin with no handshake. Mode codes: 0 single function, 1 dual function, 2 RAM 64x1, 3 RAM 2x32, 4 shift 32, 5 shift 2x16, and 6 and 7 behave like code 0. In this document the lower half means bits 0..31 and the upper half means bits 32..63.

Top module: `lut_cell`

## Requirements
- R1: In mode 0 (and the spare codes 6 and 7), out_main is store bit addr[5:0] and out_aux is lower-half bit addr[4:0]. A high wr_en at a rising edge writes wdata[0] into bit addr.
- R2: In mode 1, out_main reads upper-half bit addr[4:0] and out_aux reads lower-half bit addr[4:0]. addr[5] has no effect. A write loads wdata[1] into the upper bit and wdata[0] into the lower bit at addr[4:0].
- R3: In mode 2, a rising edge with wr_en high writes wdata[0] into bit addr[5:0] and leaves every other bit unchanged. out_main shows bit addr combinationally.
- R4: In mode 3, a rising edge with wr_en high writes wdata[1] to upper-half bit addr[4:0] and wdata[0] to lower-half bit addr[4:0]. The two halves are read as in R2.
- R5: In mode 4, each rising edge with shift_en high moves lower-half bit k-1 into bit k (for k = 1..31) and loads wdata[0] into bit 0. out_main is tap addr[4:0] and out_aux is bit 31. The upper half is not altered.
- R6: In mode 5, bits 0..15 form one 16-stage register fed by wdata[0], and bits 32..47 form a second one. The second register's input is bit 15 when cascade_en is high and wdata[1] when it is low. out_aux is tap addr[3:0] of bits 0..15 and out_main is tap addr[3:0] of bits 32..47.
- R7: In modes 4 and 5 the store does not change while shift_en is low, and wr_en has no effect.
- R8: In modes 0 to 3, shift_en has no effect on the store.
- R9: When reg_main or reg_aux is high, that output shows the value its read multiplexer had in the cycle before the last rising edge. Both flip-flops read 0 during reset (rst_n low).
- R10: Changing mode_sel does not change the stored bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the output flip-flops |
| mode_sel | input | 3 | Static mode code |
| addr | input | 6 | Read / write / tap address |
| wdata | input | 2 | Write or shift data: bit 1 upper, bit 0 lower |
| wr_en | input | 1 | Write strobe for function and RAM modes |
| shift_en | input | 1 | Shift strobe for shift modes |
| cascade_en | input | 1 | Chain the two 16-stage registers |
| reg_main | input | 1 | Register out_main |
| reg_aux | input | 1 | Register out_aux |
| out_main | output | 1 | Main output |
| out_aux | output | 1 | Auxiliary output |

## Verification
The bench aims at the points where the halves meet. With addr[5] toggled in dual modes, a cell that decodes the full address would read the wrong half. In 2x32 writes, swapped data bits would corrupt both halves. In split shift mode both cascade settings are exercised, so a wrong feed for the upper register shows up as a wrong tap value several shifts later. Shift modes are driven with wr_en high and RAM modes with shift_en high, and mode is switched over loaded contents: a design with a stray write, a stray shift or reset-on-mode-change returns stale taps. Registered outputs are compared against the previous cycle's expected read, which catches a missing or doubled flip-flop stage.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;
  typedef enum logic [2:0] {
    MODE_LUT6     = 3'd0,
    MODE_LUT5X2   = 3'd1,
    MODE_RAM64    = 3'd2,
    MODE_RAM32X2  = 3'd3,
    MODE_SHIFT32  = 3'd4,
    MODE_SHIFT16X2 = 3'd5,
    MODE_SPARE6   = 3'd6,
    MODE_SPARE7   = 3'd7
  } cell_mode_e;
endpackage

// File: rtl/lut_cell_store.sv
module lut_cell_store
  import lut_cell_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  cell_mode_e                mode,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [1:0]                wdata,
  input  logic                      wr_en,
  input  logic                      shift_en,
  input  logic                      cascade_en,
  output logic [(1<<ADDR_W)-1:0]    bits
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int HALF    = DEPTH / 2;
  localparam int SEG     = HALF / 2;
  localparam int HALF_AW = ADDR_W - 1;

  logic [DEPTH-1:0] nxt;
  logic             upper_feed;

  assign upper_feed = cascade_en ? bits[SEG-1] : wdata[1];

  always_comb begin
    nxt = bits;
    case (mode)
      MODE_SHIFT32: begin
        if (shift_en) nxt[HALF-1:0] = {bits[HALF-2:0], wdata[0]};
      end
      MODE_SHIFT16X2: begin
        if (shift_en) begin
          nxt[SEG-1:0]           = {bits[SEG-2:0], wdata[0]};
          nxt[HALF+SEG-1:HALF]   = {bits[HALF+SEG-2:HALF], upper_feed};
        end
      end
      MODE_LUT5X2, MODE_RAM32X2: begin
        if (wr_en) begin
          nxt[{1'b0, addr[HALF_AW-1:0]}] = wdata[0];
          nxt[{1'b1, addr[HALF_AW-1:0]}] = wdata[1];
        end
      end
      default: begin
        if (wr_en) nxt[addr] = wdata[0];
      end
    endcase
  end

  always_ff @(posedge clk) bits <= nxt;

  AST_RAM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode == MODE_RAM64) |=> bits[$past(addr)] == $past(wdata[0])); // R3
  AST_PAIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode == MODE_RAM32X2) |=>
      bits[{1'b1, $past(addr[HALF_AW-1:0])}] == $past(wdata[1])); // R4
  AST_SHIFT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && mode == MODE_SHIFT32) |=>
      (bits[1] == $past(bits[0]) && bits[0] == $past(wdata[0]))); // R5
  AST_UPPER_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SHIFT32) |=> $stable(bits[DEPTH-1:HALF])); // R5
  AST_CASCADE_FEED: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && cascade_en && mode == MODE_SHIFT16X2) |=> bits[HALF] == $past(bits[SEG-1])); // R6
  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && (mode == MODE_SHIFT32 || mode == MODE_SHIFT16X2)) |=> $stable(bits)); // R7
  AST_NO_STRAY_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && (mode == MODE_RAM64 || mode == MODE_LUT6)) |=> $stable(bits)); // R8
endmodule

// File: rtl/lut_cell_read.sv
module lut_cell_read
  import lut_cell_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  cell_mode_e                mode,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [(1<<ADDR_W)-1:0]    bits,
  output logic                      main_c,
  output logic                      aux_c
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int HALF    = DEPTH / 2;
  localparam int HALF_AW = ADDR_W - 1;
  localparam int SEG_AW  = ADDR_W - 2;

  logic [HALF_AW-1:0] a_half;
  logic [SEG_AW-1:0]  a_seg;

  assign a_half = addr[HALF_AW-1:0];
  assign a_seg  = addr[SEG_AW-1:0];

  always_comb begin
    case (mode)
      MODE_LUT5X2, MODE_RAM32X2: begin
        main_c = bits[{1'b1, a_half}];
        aux_c  = bits[{1'b0, a_half}];
      end
      MODE_SHIFT32: begin
        main_c = bits[{1'b0, a_half}];
        aux_c  = bits[HALF-1];
      end
      MODE_SHIFT16X2: begin
        main_c = bits[{2'b10, a_seg}];
        aux_c  = bits[{2'b00, a_seg}];
      end
      default: begin
        main_c = bits[addr];
        aux_c  = bits[{1'b0, a_half}];
      end
    endcase
  end
endmodule

// File: rtl/lut_cell_outreg.sv
module lut_cell_outreg (
  input  logic clk,
  input  logic rst_n,
  input  logic use_reg,
  input  logic d,
  output logic q
);
  logic flop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flop <= 1'b0;
    else        flop <= d;
  end

  assign q = use_reg ? flop : d;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    (!rst_n && use_reg) |-> !q); // R9
endmodule

// File: rtl/lut_cell.sv
module lut_cell
  import lut_cell_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        wdata,
  input  logic              wr_en,
  input  logic              shift_en,
  input  logic              cascade_en,
  input  logic              reg_main,
  input  logic              reg_aux,
  output logic              out_main,
  output logic              out_aux
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int N_OUT = 2;

  cell_mode_e        mode;
  logic [DEPTH-1:0]  bits;
  logic [N_OUT-1:0]  comb_v, sel_v, out_v;

  assign mode = cell_mode_e'(mode_sel);

  lut_cell_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .mode(mode), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .shift_en(shift_en), .cascade_en(cascade_en), .bits(bits)
  );

  lut_cell_read #(.ADDR_W(ADDR_W)) u_read (
    .mode(mode), .addr(addr), .bits(bits), .main_c(comb_v[0]), .aux_c(comb_v[1])
  );

  assign sel_v = {reg_aux, reg_main};

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    lut_cell_outreg u_oreg (
      .clk(clk), .rst_n(rst_n), .use_reg(sel_v[i]), .d(comb_v[i]), .q(out_v[i])
    );
  end

  assign out_main = out_v[0];
  assign out_aux  = out_v[1];

  AST_MODE_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !shift_en) |=> $stable(bits)); // R10
endmodule

// File: tb/lut_cell_test.sv
`timescale 1ns/1ps
module lut_cell_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [2:0] mode_sel = 0;
  logic [5:0] addr = 0;
  logic [1:0] wdata = 0;
  logic       wr_en = 0, shift_en = 0, cascade_en = 0, reg_main = 0, reg_aux = 0;
  logic       out_main, out_aux;

  int checks = 0;
  int errors = 0;
  logic [63:0] m = 64'd0;
  logic last_m = 0, last_a = 0;

  always #2.5 clk = ~clk;

  lut_cell uut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .shift_en(shift_en), .cascade_en(cascade_en),
    .reg_main(reg_main), .reg_aux(reg_aux), .out_main(out_main), .out_aux(out_aux)
  );

  function automatic logic exp_main(input logic [2:0] md, input logic [5:0] a, input logic [63:0] s);
    case (md)
      3'd1, 3'd3: return s[{1'b1, a[4:0]}];
      3'd4:       return s[{1'b0, a[4:0]}];
      3'd5:       return s[32 + a[3:0]];
      default:    return s[a];
    endcase
  endfunction

  function automatic logic exp_aux(input logic [2:0] md, input logic [5:0] a, input logic [63:0] s);
    case (md)
      3'd4:    return s[31];
      3'd5:    return s[a[3:0]];
      default: return s[{1'b0, a[4:0]}];
    endcase
  endfunction

  function automatic logic [63:0] exp_next(input logic [2:0] md, input logic [5:0] a,
      input logic [1:0] wd, input logic we, input logic se, input logic ce, input logic [63:0] s);
    logic [63:0] n = s;
    case (md)
      3'd4: if (se) for (int k = 31; k > 0; k--) n[k] = s[k-1];
      3'd5: if (se) for (int k = 15; k > 0; k--) begin n[k] = s[k-1]; n[32+k] = s[32+k-1]; end
      3'd1, 3'd3: if (we) begin n[a[4:0]] = wd[0]; n[32 + a[4:0]] = wd[1]; end
      default: if (we) n[a] = wd[0];
    endcase
    if (md == 3'd4 && se) n[0] = wd[0];
    if (md == 3'd5 && se) begin n[0] = wd[0]; n[32] = ce ? s[15] : wd[1]; end
    return n;
  endfunction

  function automatic string tag_of(input logic [2:0] md);
    case (md)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      default: return "R1";
    endcase
  endfunction

  task automatic check(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] md, input logic [5:0] a, input logic [1:0] wd,
      input logic we, input logic se, input logic ce, input logic rm, input logic ra,
      input string tag);
    string t;
    logic em, ea;
    @(negedge clk);
    mode_sel = md; addr = a; wdata = wd; wr_en = we; shift_en = se;
    cascade_en = ce; reg_main = rm; reg_aux = ra;
    #1;
    t = (tag == "") ? tag_of(md) : tag;
    em = exp_main(md, a, m);
    ea = exp_aux(md, a, m);
    if (rm) check(out_main, last_m, "R9", "registered out_main");
    else    check(out_main, em, t, "out_main");
    if (ra) check(out_aux, last_a, "R9", "registered out_aux");
    else    check(out_aux, ea, t, "out_aux");
    @(posedge clk);
    last_m = em;
    last_a = ea;
    m = exp_next(md, a, wd, we, se, ce, m);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    // R9: flip-flops clear in reset
    reg_main = 1; reg_aux = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_main, 1'b0, "R9", "reset out_main");
    check(out_aux,  1'b0, "R9", "reset out_aux");
    rst_n = 1;

    // R1: load all bits through the write path, then read back
    for (int i = 0; i < 64; i++) step(3'd0, 6'(i), {1'b0, 1'($urandom)}, 1, 0, 0, 0, 0, "R1");
    for (int i = 0; i < 64; i++) step(3'd0, 6'(i), 2'b00, 0, 0, 0, 0, 0, "R1");
    // R2 / R10: same store seen as two functions, addr[5] both ways
    for (int i = 0; i < 64; i++) step(3'd1, 6'(i), 2'b00, 0, 0, 0, 0, 0, "R10");
    // R4: paired writes with distinct data bits
    for (int i = 0; i < 32; i++) step(3'd3, 6'(i), 2'(i), 1, 0, 0, 0, 0, "R4");
    for (int i = 0; i < 32; i++) step(3'd3, 6'(i), 2'b00, 0, 0, 0, 0, 0, "R4");
    // R8: shift strobe in RAM mode
    for (int i = 0; i < 64; i++) step(3'd2, 6'(i), 2'b11, 0, 1, 0, 0, 0, "R8");
    // R5: fill 32-stage register, then read every tap
    for (int i = 0; i < 40; i++) step(3'd4, 6'(i), 2'($urandom), 0, 1, 0, 0, 0, "R5");
    // R7: write strobe in shift mode with shifting stopped
    for (int i = 0; i < 32; i++) step(3'd4, 6'(i), 2'b11, 1, 0, 0, 0, 0, "R7");
    // R6: split registers, independent then cascaded
    for (int i = 0; i < 20; i++) step(3'd5, 6'(i), 2'($urandom), 0, 1, 0, 0, 0, "R6");
    for (int i = 0; i < 20; i++) step(3'd5, 6'(i), 2'($urandom), 0, 1, 1, 0, 0, "R6");
    for (int i = 0; i < 16; i++) step(3'd5, 6'(i), 2'b10, 1, 0, 1, 0, 0, "R7");
    // R9: registered outputs
    for (int i = 0; i < 64; i++) step(3'd0, 6'($urandom), 2'b00, 0, 0, 0, 1, 1, "");
    // random mix of all modes and controls
    for (int i = 0; i < 4000; i++)
      step(3'($urandom), 6'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), 1'($urandom), "");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule